// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a small multicycle processor for a machine whose memory holds 65,536 words of 16 bits each. Each instruction first reads the word at the program counter into the instruction register and steps the program counter by one. The core then decodes the word and forms an address where one is needed. It reads operands, computes, and writes the result back. All memory traffic passes through one synchronous single-port interface. A registered address (MAR) and a registered write-data word (MDR) drive that interface, and read data returns one clock after the address is presented.

The core runs three operate instructions (ADD, AND, NOT) and seven data-movement instructions: PC-relative load and store, indirect load and store, base+offset load and store, and load-effective-address. It has eight general registers and a three-bit negative/zero/positive condition code. Any other opcode passes as a no-operation. A halt input freezes the sequencer, so that a test environment can look at the program counter and condition code while nothing moves.

Top module: `cpu16_core`

## Requirements
- R1: While reset is high the program counter is 0x3000, the condition code is Z (`cc_out` = 3'b010, bit 2 = N, bit 1 = Z, bit 0 = P), `mem_we` is 0 and all eight general registers are 0.
- R2: Each instruction starts by reading the word at the program counter into the instruction register and adding 1 to the program counter. The opcode is held in bits 15:12.
- R3: Operate instructions use opcodes ADD=0001, AND=0101 and NOT=1001. The destination is in bits 11:9 and the first source is in bits 8:6. For ADD and AND, bit 5 = 1 selects the immediate in bits 4:0, sign-extended; bit 5 = 0 selects the register in bits 2:0. NOT inverts the first source.
- R4: LD (0010) and ST (0011) address memory at the incremented program counter plus the sign-extended 9-bit offset in bits 8:0. Negative offsets reach backwards.
- R5: LDR (0110) and STR (0111) address memory at the register named in bits 8:6 plus the sign-extended 6-bit offset in bits 5:0.
- R6: LDI (1010) and STI (1011) first read a pointer word at the PC-relative address, then load from or store to the address held in that pointer.
- R7: LEA (1110) writes the PC-relative address itself into the destination register and makes no memory access.
- R8: Every register write sets exactly one of N, Z and P from the written value. Stores leave the condition code unchanged.
- R9: Opcodes outside the listed set change no register, condition code or memory word. Execution continues at the next word.
- R10: While `halt` is high, the program counter, condition code, registers and memory interface outputs hold their values.
- R11: A store asserts `mem_we` for exactly one cycle. The data written is the register named in bits 11:9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freezes the sequencer while high |
| mem_addr | output | 16 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MDR) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| pc_out | output | 16 | Current program counter |
| cc_out | output | 3 | Condition code {N,Z,P} |

## Verification
A single program exercises each addressing mode. Loads feed sums, differences and masks into stores, so every stored word shows a different data path. A positive and a negative offset separate correct sign extension from plain zero extension. The STR to a lower address and the backward LD probe sign extension in the 6-bit and 9-bit fields respectively. The condition code is compared at each store after results that are positive, negative and zero. An indirect store whose pointer targets a location that no other instruction writes shows that the pointer was followed and not used as data. The no-op word and the halt window show that nothing changes when nothing should.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int XLEN = 16;

  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_AND = 4'b0101;
  localparam logic [3:0] OP_NOT = 4'b1001;
  localparam logic [3:0] OP_LD  = 4'b0010;
  localparam logic [3:0] OP_LDI = 4'b1010;
  localparam logic [3:0] OP_LDR = 4'b0110;
  localparam logic [3:0] OP_ST  = 4'b0011;
  localparam logic [3:0] OP_STI = 4'b1011;
  localparam logic [3:0] OP_STR = 4'b0111;
  localparam logic [3:0] OP_LEA = 4'b1110;

  typedef enum logic [2:0] {
    S_FETCH, S_FWAIT, S_IRLD, S_DECODE, S_RWAIT, S_RDATA, S_WRITE
  } seq_t;

  function automatic logic [2:0] flags_of(input logic [XLEN-1:0] v);
    logic neg, zer;
    neg = v[XLEN-1];
    zer = (v == '0);
    return {neg, zer, ~neg & ~zer};
  endfunction
endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (wen) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/cpu16_agen.sv
module cpu16_agen
  import cpu16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] instr,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] base,
  output logic [W-1:0] addr
);
  logic [W-1:0] off9, off6;
  logic         use_base;

  assign off9     = {{(W-9){instr[8]}}, instr[8:0]};
  assign off6     = {{(W-6){instr[5]}}, instr[5:0]};
  assign use_base = (instr[15:12] == OP_LDR) || (instr[15:12] == OP_STR);
  assign addr     = use_base ? (base + off6) : (pc + off9);
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] instr,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic [W-1:0] result
);
  logic [W-1:0] imm5, opnd_b;

  assign imm5   = {{(W-5){instr[4]}}, instr[4:0]};
  assign opnd_b = instr[5] ? imm5 : src_b;

  always_comb begin
    unique case (instr[15:12])
      OP_ADD:  result = src_a + opnd_b;
      OP_AND:  result = src_a & opnd_b;
      OP_NOT:  result = ~src_a;
      default: result = src_a;
    endcase
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int               NREG     = 8,
  parameter logic [XLEN-1:0]  RESET_PC = 16'h3000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] pc_out,
  output logic [2:0]      cc_out
);
  localparam int RAW = $clog2(NREG);

  seq_t            state_q;
  logic [XLEN-1:0] pc_q, ir_q, mar_q, mdr_q;
  logic            we_q, ptr_q;
  logic [2:0]      cc_q;

  logic [3:0]      op;
  logic            is_store, is_load, is_oper;
  logic [XLEN-1:0] rd_a, rd_b, ea, alu_y, wb_data;
  logic            wb_en;

  assign op       = ir_q[15:12];
  assign is_store = (op == OP_ST) || (op == OP_STR) || (op == OP_STI);
  assign is_load  = (op == OP_LD) || (op == OP_LDR) || (op == OP_LDI);
  assign is_oper  = (op == OP_ADD) || (op == OP_AND) || (op == OP_NOT);

  cpu16_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wen     (wb_en),
    .waddr   (ir_q[11:9]),
    .wdata   (wb_data),
    .raddr_a (ir_q[8:6]),
    .raddr_b (is_store ? ir_q[11:9] : ir_q[2:0]),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  cpu16_agen #(.W(XLEN)) u_agen (
    .instr (ir_q),
    .pc    (pc_q),
    .base  (rd_a),
    .addr  (ea)
  );

  cpu16_alu #(.W(XLEN)) u_alu (
    .instr  (ir_q),
    .src_a  (rd_a),
    .src_b  (rd_b),
    .result (alu_y)
  );

  always_comb begin
    wb_en = 1'b0;
    if (!halt) begin
      if (state_q == S_DECODE && (is_oper || op == OP_LEA)) wb_en = 1'b1;
      if (state_q == S_RDATA && !ptr_q && is_load)          wb_en = 1'b1;
    end
    if (state_q == S_RDATA)  wb_data = mem_rdata;
    else if (op == OP_LEA)   wb_data = ea;
    else                     wb_data = alu_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      we_q    <= 1'b0;
      ptr_q   <= 1'b0;
      cc_q    <= 3'b010;
    end else if (!halt) begin
      if (wb_en) cc_q <= flags_of(wb_data);
      unique case (state_q)
        S_FETCH: begin
          mar_q   <= pc_q;
          pc_q    <= pc_q + 1'b1;
          state_q <= S_FWAIT;
        end
        S_FWAIT: state_q <= S_IRLD;
        S_IRLD: begin
          ir_q    <= mem_rdata;
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          state_q <= S_FETCH;
          if (is_load || op == OP_STI) begin
            mar_q   <= ea;
            ptr_q   <= (op == OP_LDI) || (op == OP_STI);
            state_q <= S_RWAIT;
          end else if (is_store) begin
            mar_q   <= ea;
            mdr_q   <= rd_b;
            we_q    <= 1'b1;
            state_q <= S_WRITE;
          end
        end
        S_RWAIT: state_q <= S_RDATA;
        S_RDATA: begin
          state_q <= S_FETCH;
          if (ptr_q) begin
            mar_q <= mem_rdata;
            ptr_q <= 1'b0;
            if (op == OP_STI) begin
              mdr_q   <= rd_b;
              we_q    <= 1'b1;
              state_q <= S_WRITE;
            end else begin
              state_q <= S_RWAIT;
            end
          end
        end
        S_WRITE: begin
          we_q    <= 1'b0;
          state_q <= S_FETCH;
        end
        default: state_q <= S_FETCH;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = we_q;
  assign pc_out    = pc_q;
  assign cc_out    = cc_q;
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            halt,
  input logic [XLEN-1:0] pc,
  input logic [2:0]      cc,
  input logic            we,
  input seq_t            st,
  input logic [3:0]      op
);
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc == 16'h3000 && !we && cc == 3'b010))
    else $error("R1 reset state wrong");

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH && !halt) |=> (pc == $past(pc) + 16'd1))
    else $error("R2 pc did not step");

  a_r7_lea_no_access: assert property (@(posedge clk) disable iff (rst)
    (st == S_DECODE && op == OP_LEA && !halt) |=> (!we && st == S_FETCH))
    else $error("R7 LEA touched memory");

  a_r8_cc_onehot: assert property (@(posedge clk) disable iff (rst) $countones(cc) == 1)
    else $error("R8 flags not one-hot");

  a_r8_store_keeps_cc: assert property (@(posedge clk) disable iff (rst)
    (we && !halt) |=> $stable(cc))
    else $error("R8 store changed flags");

  a_r10_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(pc) && $stable(cc) && $stable(we)))
    else $error("R10 halt did not freeze");

  a_r11_we_pulse: assert property (@(posedge clk) disable iff (rst)
    (we && !halt) |=> !we)
    else $error("R11 write enable longer than one cycle");
endmodule

bind cpu16_core cpu16_core_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .halt (halt),
  .pc   (pc_q),
  .cc   (cc_q),
  .we   (we_q),
  .st   (state_q),
  .op   (ir_q[15:12])
);

// File: tb/sim_cpu16_core.sv
`timescale 1ns/1ps
module sim_cpu16_core;
  localparam int MAW = 10;
  localparam logic [2:0] FN = 3'b100, FZ = 3'b010, FP = 3'b001;

  logic clk = 1'b0, rst = 1'b1, halt = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_out;
  logic        mem_we;
  logic [2:0]  cc_out;
  logic        ld_en = 1'b0;
  logic [15:0] ld_a = '0, ld_d = '0;
  logic [15:0] mem [1 << MAW];

  int n_cmp = 0, n_bad = 0, n_st = 0;
  bit done = 0;

  typedef struct packed { logic [15:0] a; logic [15:0] d; logic [2:0] f; } exp_t;
  exp_t  sb_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cpu16_core u0 (
    .clk(clk), .rst(rst), .halt(halt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .cc_out(cc_out)
  );

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_a[MAW-1:0]] <= ld_d;
    else if (mem_we) mem[mem_addr[MAW-1:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[MAW-1:0]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic expect_store(input string req, input logic [15:0] a,
                              input logic [15:0] d, input logic [2:0] f);
    sb_q.push_back('{a: a, d: d, f: f});
    tag_q.push_back(req);
  endtask

  function automatic logic [15:0] e_rel(input logic [3:0] op, input int r,
                                        input logic [15:0] here, input logic [15:0] tgt);
    logic [15:0] off;
    off = tgt - (here + 16'd1);
    return {op, r[2:0], off[8:0]};
  endfunction

  function automatic logic [15:0] e_base(input logic [3:0] op, input int r,
                                         input int b, input int off);
    logic [5:0] o6;
    o6 = off[5:0];
    return {op, r[2:0], b[2:0], o6};
  endfunction

  function automatic logic [15:0] e_opr(input logic [3:0] op, input int d, input int s,
                                        input logic imm, input int low);
    logic [4:0] l5;
    l5 = low[4:0];
    return {op, d[2:0], s[2:0], imm, l5};
  endfunction

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      n_st++;
      if (sb_q.size() == 0) begin
        check("R9/R10 unexpected store", {16'h0, mem_addr}, 32'hFFFF_FFFF);
      end else begin
        exp_t  e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check({t, " addr"}, {16'h0, mem_addr}, {16'h0, e.a});
        check({t, " data R11"}, {16'h0, mem_wdata}, {16'h0, e.d});
        check({t, " flags R8"}, {29'h0, cc_out}, {29'h0, e.f});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w3000, pc_snap;
    w3000 = e_rel(4'b0010, 1, 16'h3000, 16'h3040);

    for (int i = 0; i < 256; i++) poke(16'h3000 + 16'(i), 16'h0000);
    poke(16'h3000, w3000);
    poke(16'h3001, e_rel(4'b0010, 2, 16'h3001, 16'h3041));
    poke(16'h3002, e_opr(4'b0001, 3, 1, 1'b0, 2));
    poke(16'h3003, e_rel(4'b0011, 3, 16'h3003, 16'h3050));
    poke(16'h3004, e_opr(4'b1001, 4, 1, 1'b1, 31));
    poke(16'h3005, e_opr(4'b0001, 4, 4, 1'b1, 1));
    poke(16'h3006, e_opr(4'b0001, 5, 2, 1'b0, 4));
    poke(16'h3007, e_rel(4'b0011, 5, 16'h3007, 16'h3051));
    poke(16'h3008, e_opr(4'b0101, 6, 2, 1'b1, 15));
    poke(16'h3009, e_rel(4'b0011, 6, 16'h3009, 16'h3052));
    poke(16'h300A, e_rel(4'b1110, 0, 16'h300A, 16'h3040));
    poke(16'h300B, e_base(4'b0110, 7, 0, 2));
    poke(16'h300C, e_base(4'b0111, 7, 0, -1));
    poke(16'h300D, e_rel(4'b1010, 1, 16'h300D, 16'h3043));
    poke(16'h300E, e_rel(4'b1011, 1, 16'h300E, 16'h3045));
    poke(16'h300F, 16'hD000);
    poke(16'h3010, e_rel(4'b0011, 0, 16'h3010, 16'h3054));
    poke(16'h3011, e_opr(4'b0101, 2, 2, 1'b1, 0));
    poke(16'h3012, e_rel(4'b0011, 2, 16'h3012, 16'h3055));
    poke(16'h3013, e_rel(4'b0010, 3, 16'h3013, 16'h3000));
    poke(16'h3014, e_rel(4'b0011, 3, 16'h3014, 16'h3056));
    poke(16'h3040, 16'd26);
    poke(16'h3041, 16'd67);
    poke(16'h3042, 16'h8001);
    poke(16'h3043, 16'h3044);
    poke(16'h3044, 16'h1234);
    poke(16'h3045, 16'h3053);

    expect_store("R3 R4 add of loads",      16'h3050, 16'd93,   FP);
    expect_store("R3 not/add-imm subtract",  16'h3051, 16'd41,   FP);
    expect_store("R3 and-imm mask",          16'h3052, 16'd3,    FP);
    expect_store("R5 base+neg offset",       16'h303F, 16'h8001, FN);
    expect_store("R6 indirect pair",         16'h3053, 16'h1234, FP);
    expect_store("R7 R9 lea after nop",      16'h3054, 16'h3040, FP);
    expect_store("R8 zero result",           16'h3055, 16'h0000, FZ);
    expect_store("R4 R2 backward offset",    16'h3056, w3000,    FP);

    @(negedge clk);
    check("R1 reset pc",    {16'h0, pc_out}, 32'h3000);
    check("R1 reset we",    {31'h0, mem_we}, 32'h0);
    check("R1 reset flags", {29'h0, cc_out}, {29'h0, FZ});
    rst = 1'b0;

    while (sb_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R2 stores seen", n_st, 8);

    halt = 1'b1;
    @(negedge clk);
    pc_snap = pc_out;
    repeat (20) @(negedge clk);
    check("R10 pc frozen", {16'h0, pc_out}, {16'h0, pc_snap});
    check("R10 flags frozen", {29'h0, cc_out}, {29'h0, FP});
    halt = 1'b0;
    repeat (20) @(negedge clk);
    check("R2 R9 pc resumes", {31'h0, pc_out != pc_snap}, 32'h1);
    check("R9 no extra stores", n_st, 8);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule